// File: doc/BRIEF.md
# Paged Memory Region Decoder

This block classifies one processor access per request into the memory region that serves it. An access carries a space selector (program or data), a 16-bit offset, a 7-bit program page number, a write flag and a flag marking the requester as a DMA engine. Four mode inputs steer the decode: overlay, microprocessor mode, data-ROM enable and boot-ROM enable. A fifth input, the external-interface enable pin, gates every access that leaves the chip. The possible targets are local dual-access RAM, local single-access RAM, one of four shared program RAM blocks, boot ROM, external memory, memory-mapped registers and reserved space.

Each result gives a region code, a block index within that region, a word address within the region and a blocked flag. A blocked write is meant to be dropped. A blocked read is meant to return a value flagged as unknown. The result appears one clock after the request strobe and is held until the next request. The memory arrays are not part of the block.

Top module: `pmd_region_decoder`

## Requirements
- R1: In program space, a lower-half offset (below 8000h) that is not reserved decodes as local dual-access RAM when overlay is 1 and as external when overlay is 0, on every page.
- R2: In program space with microprocessor mode 0, an upper-half offset decodes as shared RAM with block index equal to the page for effective pages 0 to 3. It decodes as external for effective pages 4 to 7.
- R3: With microprocessor mode 1, every upper-half program offset decodes as external, whatever the page and ROM enable.
- R4: Only page bits [2:0] select the effective page: pages 8 to 127 decode exactly as the page given by the page number modulo 8.
- R5: In data space the page is ignored. Offsets 0060h to 7FFFh decode as local dual-access RAM. Upper-half offsets decode as local single-access RAM when data-ROM enable is 1 and as external when it is 0.
- R6: A write that decodes as shared RAM is blocked unless the DMA flag is 1. Reads of shared RAM are never blocked.
- R7: When the external-interface enable is 0, every access (read or write) that decodes as external is blocked. When it is 1, external accesses are not blocked.
- R8: With ROM enable 1, program offsets E000h to FFFFh on effective page 0 decode as boot ROM, with word address equal to offset minus E000h. A non-DMA write there is blocked. With ROM enable 0, or on other pages, the same offsets decode as shared RAM.
- R9: Offsets 0000h to 005Fh decode as memory-mapped registers in data space. In program space on effective pages 0 to 3 they decode as reserved. On effective pages 4 to 7 they follow R1.
- R10: Outputs update on the clock edge that samples req_valid high, and rsp_valid is req_valid delayed by one cycle. Region codes are: 0 dual-access RAM, 1 single-access RAM, 2 shared RAM, 3 boot ROM, 4 external, 5 registers, 6 reserved. For local RAMs the block index is offset bits [14:13]. For the other regions other than shared RAM it is 0. The word address is offset bits [14:0], except in boot ROM (R8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_data_space | input | 1 | 1 = data space, 0 = program space |
| req_offset | input | 16 | Word offset within the space |
| req_page | input | 7 | Program page extension |
| req_write | input | 1 | 1 = write access |
| req_dma | input | 1 | 1 = requester is a DMA engine |
| mode_overlay | input | 1 | Maps local dual-access RAM into program space |
| mode_micro | input | 1 | Microprocessor mode: upper program half is external |
| mode_drom | input | 1 | Enables local single-access RAM in upper data half |
| mode_romen | input | 1 | Enables boot ROM window on page 0 |
| xif_enable | input | 1 | External-interface enable pin |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_region | output | 3 | Region code |
| rsp_block | output | 2 | Block index within region |
| rsp_addr | output | 15 | Word address within region |
| rsp_blocked | output | 1 | Access must not complete |

## Verification
Several rules are checked on every cycle by assertions:
- the one-cycle result latency;
- that no unblocked non-DMA write reaches shared RAM;
- that nothing external passes while the interface is disabled;
- that data space never yields a program-only region;
- that microprocessor mode forces the upper program half external.

Other behaviour is shown only by the bench's scenarios against its behavioural model. This covers the exact region for each mode mix, the page aliasing, the ROM window edges at DFFFh and E000h, the 005Fh/0060h register boundary, and the block and address fields.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
   typedef enum logic [2:0] {
      RGN_DARAM  = 3'd0,
      RGN_SARAM  = 3'd1,
      RGN_SHARED = 3'd2,
      RGN_ROM    = 3'd3,
      RGN_EXT    = 3'd4,
      RGN_MMR    = 3'd5,
      RGN_RSVD   = 3'd6
   } region_e;
endpackage

// File: rtl/pmd_data_dec.sv
module pmd_data_dec
   import pmd_pkg::*;
#(
   parameter int OFS_W   = 16,
   parameter int BLK_W   = 2,
   parameter int MMR_TOP = 'h60
) (
   input  logic [OFS_W-1:0] offset,
   input  logic             drom,
   output region_e          region,
   output logic [BLK_W-1:0] block
);
   localparam int MSB = OFS_W - 1;

   always_comb begin
      region = RGN_EXT;
      block  = '0;
      if (offset < OFS_W'(MMR_TOP)) begin
         region = RGN_MMR;
      end else if (!offset[MSB]) begin
         region = RGN_DARAM;
         block  = offset[MSB-1 -: BLK_W];
      end else if (drom) begin
         region = RGN_SARAM;
         block  = offset[MSB-1 -: BLK_W];
      end
   end
endmodule

// File: rtl/pmd_prog_dec.sv
module pmd_prog_dec
   import pmd_pkg::*;
#(
   parameter int OFS_W        = 16,
   parameter int PAGE_W       = 7,
   parameter int REAL_PAGE_W  = 3,
   parameter int SHARED_PAGES = 4,
   parameter int BLK_W        = 2,
   parameter int MMR_TOP      = 'h60,
   parameter int ROM_BASE     = 'hE000,
   parameter bit ALIAS_PAGES  = 1'b1
) (
   input  logic [OFS_W-1:0]  offset,
   input  logic [PAGE_W-1:0] page,
   input  logic              overlay,
   input  logic              micro,
   input  logic              romen,
   output region_e           region,
   output logic [BLK_W-1:0]  block
);
   localparam int MSB = OFS_W - 1;

   logic [REAL_PAGE_W-1:0] eff_page;
   logic                   out_of_range;
   logic                   low_page;

   generate
      if (ALIAS_PAGES) begin : g_alias
         logic unused_page_hi;
         assign eff_page       = page[REAL_PAGE_W-1:0];
         assign out_of_range   = 1'b0;
         assign unused_page_hi = ^page[PAGE_W-1:REAL_PAGE_W];
      end else begin : g_strict
         assign eff_page     = page[REAL_PAGE_W-1:0];
         assign out_of_range = |page[PAGE_W-1:REAL_PAGE_W];
      end
   endgenerate

   assign low_page = !out_of_range && (eff_page < REAL_PAGE_W'(SHARED_PAGES));

   always_comb begin
      region = RGN_EXT;
      block  = '0;
      if (!offset[MSB]) begin
         if (low_page && (offset < OFS_W'(MMR_TOP))) begin
            region = RGN_RSVD;
         end else if (overlay) begin
            region = RGN_DARAM;
            block  = offset[MSB-1 -: BLK_W];
         end
      end else if (!micro && low_page) begin
         if ((eff_page == '0) && romen && (offset >= OFS_W'(ROM_BASE))) begin
            region = RGN_ROM;
         end else begin
            region = RGN_SHARED;
            block  = eff_page[BLK_W-1:0];
         end
      end
   end
endmodule

// File: rtl/pmd_block_gate.sv
module pmd_block_gate
   import pmd_pkg::*;
(
   input  region_e region,
   input  logic    write,
   input  logic    dma,
   input  logic    xif_enable,
   output logic    blocked
);
   logic ext_stop;
   logic cpu_write_stop;

   assign ext_stop       = (region == RGN_EXT) && !xif_enable;
   assign cpu_write_stop = write && !dma && ((region == RGN_SHARED) || (region == RGN_ROM));
   assign blocked        = ext_stop || cpu_write_stop;
endmodule

// File: rtl/pmd_region_decoder.sv
module pmd_region_decoder
   import pmd_pkg::*;
#(
   parameter int OFS_W        = 16,
   parameter int PAGE_W       = 7,
   parameter int REAL_PAGE_W  = 3,
   parameter int SHARED_PAGES = 4,
   parameter int BLK_W        = 2,
   parameter int MMR_TOP      = 'h60,
   parameter int ROM_BASE     = 'hE000,
   parameter bit ALIAS_PAGES  = 1'b1,
   localparam int AW          = OFS_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_data_space,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic [PAGE_W-1:0] req_page,
   input  logic              req_write,
   input  logic              req_dma,
   input  logic              mode_overlay,
   input  logic              mode_micro,
   input  logic              mode_drom,
   input  logic              mode_romen,
   input  logic              xif_enable,
   output logic              rsp_valid,
   output logic [2:0]        rsp_region,
   output logic [BLK_W-1:0]  rsp_block,
   output logic [AW-1:0]     rsp_addr,
   output logic              rsp_blocked
);
   generate
      if (PAGE_W <= REAL_PAGE_W) begin : g_chk_page
         $error("PAGE_W must exceed REAL_PAGE_W");
      end
      if (SHARED_PAGES != (1 << BLK_W)) begin : g_chk_blk
         $error("SHARED_PAGES must equal 2**BLK_W");
      end
      if (SHARED_PAGES > (1 << REAL_PAGE_W)) begin : g_chk_shared
         $error("SHARED_PAGES exceeds real page count");
      end
      if ((ROM_BASE < (1 << AW)) || (ROM_BASE >= (1 << OFS_W))) begin : g_chk_rom
         $error("ROM_BASE must lie in the upper half");
      end
      if (MMR_TOP >= (1 << AW)) begin : g_chk_mmr
         $error("MMR_TOP must lie in the lower half");
      end
   endgenerate

   region_e          d_region, p_region, sel_region;
   logic [BLK_W-1:0] d_block, p_block, sel_block;
   logic [AW-1:0]    sel_addr;
   logic             sel_blocked;
   logic [OFS_W-1:0] rom_rel;

   pmd_data_dec #(.OFS_W(OFS_W), .BLK_W(BLK_W), .MMR_TOP(MMR_TOP)) u_data (
      .offset(req_offset), .drom(mode_drom), .region(d_region), .block(d_block)
   );

   pmd_prog_dec #(
      .OFS_W(OFS_W), .PAGE_W(PAGE_W), .REAL_PAGE_W(REAL_PAGE_W),
      .SHARED_PAGES(SHARED_PAGES), .BLK_W(BLK_W), .MMR_TOP(MMR_TOP),
      .ROM_BASE(ROM_BASE), .ALIAS_PAGES(ALIAS_PAGES)
   ) u_prog (
      .offset(req_offset), .page(req_page), .overlay(mode_overlay),
      .micro(mode_micro), .romen(mode_romen), .region(p_region), .block(p_block)
   );

   assign sel_region = req_data_space ? d_region : p_region;
   assign sel_block  = req_data_space ? d_block  : p_block;
   assign rom_rel    = req_offset - OFS_W'(ROM_BASE);
   assign sel_addr   = (sel_region == RGN_ROM) ? rom_rel[AW-1:0] : req_offset[AW-1:0];

   pmd_block_gate u_gate (
      .region(sel_region), .write(req_write), .dma(req_dma),
      .xif_enable(xif_enable), .blocked(sel_blocked)
   );

   region_e q_region;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         q_region    <= RGN_DARAM;
         rsp_block   <= '0;
         rsp_addr    <= '0;
         rsp_blocked <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            q_region    <= sel_region;
            rsp_block   <= sel_block;
            rsp_addr    <= sel_addr;
            rsp_blocked <= sel_blocked;
         end
      end
   end

   assign rsp_region = q_region;

   // R10: one-cycle latency of the strobe
   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R6: no unblocked non-DMA write lands in shared RAM
   p_shared_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_dma) |=> !((q_region == RGN_SHARED) && !rsp_blocked));
   // R7: external access never passes with the interface disabled
   p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !xif_enable) |=> !((q_region == RGN_EXT) && !rsp_blocked));
   // R5: data space never reaches program-only regions
   p_data_regions_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_data_space) |=>
      ((q_region != RGN_SHARED) && (q_region != RGN_ROM) && (q_region != RGN_RSVD)));
   // R3: microprocessor mode forces the upper program half external
   p_micro_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_data_space && req_offset[OFS_W-1] && mode_micro) |=>
      (q_region == RGN_EXT));
endmodule

// File: tb/pmd_region_decoder_tb.sv
module pmd_region_decoder_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_data_space = 1'b0, req_write = 1'b0, req_dma = 1'b0;
   logic [15:0] req_offset = '0;
   logic [6:0]  req_page = '0;
   logic        mode_overlay = 1'b0, mode_micro = 1'b0, mode_drom = 1'b0, mode_romen = 1'b0;
   logic        xif_enable = 1'b1;
   logic        rsp_valid, rsp_blocked;
   logic [2:0]  rsp_region;
   logic [1:0]  rsp_block;
   logic [14:0] rsp_addr;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmd_region_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data_space(req_data_space),
      .req_offset(req_offset), .req_page(req_page), .req_write(req_write), .req_dma(req_dma),
      .mode_overlay(mode_overlay), .mode_micro(mode_micro), .mode_drom(mode_drom),
      .mode_romen(mode_romen), .xif_enable(xif_enable), .rsp_valid(rsp_valid),
      .rsp_region(rsp_region), .rsp_block(rsp_block), .rsp_addr(rsp_addr),
      .rsp_blocked(rsp_blocked)
   );

   // Behavioural reference built from the requirements
   task automatic model(input bit sp, input int off, input int pg, input bit wr, input bit dma,
                        input bit ov, input bit mp, input bit dr, input bit ro, input bit xi,
                        output int rg, output int blk, output int adr, output bit bl);
      int p;
      p   = pg % 8;
      blk = 0;
      adr = off % 32768;
      if (sp) begin
         if (off < 96) rg = 5;
         else if (off < 32768) begin rg = 0; blk = off / 8192; end
         else if (dr) begin rg = 1; blk = (off - 32768) / 8192; end
         else rg = 4;
      end else if (off < 32768) begin
         if (p < 4 && off < 96) rg = 6;
         else if (ov) begin rg = 0; blk = off / 8192; end
         else rg = 4;
      end else if (mp || p >= 4) rg = 4;
      else if (p == 0 && ro && off >= 57344) begin rg = 3; adr = off - 57344; end
      else begin rg = 2; blk = p; end
      bl = (rg == 4 && !xi) || ((rg == 2 || rg == 3) && wr && !dma);
   endtask

   task automatic issue(input string tag, input bit sp, input int off, input int pg,
                        input bit wr, input bit dma);
      int erg, eblk, eadr;
      bit ebl;
      @(negedge clk);
      req_valid = 1'b1; req_data_space = sp; req_offset = off[15:0];
      req_page = pg[6:0]; req_write = wr; req_dma = dma;
      model(sp, off, pg, wr, dma, mode_overlay, mode_micro, mode_drom, mode_romen,
            xif_enable, erg, eblk, eadr, ebl);
      @(posedge clk);
      #1;
      checks++;
      if (!rsp_valid || rsp_region != erg[2:0] || rsp_block != eblk[1:0] ||
          rsp_addr != eadr[14:0] || rsp_blocked != ebl) begin
         failures++;
         $display("FAIL %s: got v=%0d rg=%0d blk=%0d adr=%h bl=%0d exp v=1 rg=%0d blk=%0d adr=%h bl=%0d",
                  tag, rsp_valid, rsp_region, rsp_block, rsp_addr, rsp_blocked,
                  erg, eblk, eadr[14:0], ebl);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_mode(input bit ov, input bit mp, input bit dr, input bit ro, input bit xi);
      @(negedge clk);
      mode_overlay = ov; mode_micro = mp; mode_drom = dr; mode_romen = ro; xif_enable = xi;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (rsp_valid !== 1'b0 || rsp_region !== 3'd0 || rsp_blocked !== 1'b0) begin
         failures++;
         $display("FAIL R10 reset: got v=%0d rg=%0d bl=%0d exp 0 0 0", rsp_valid, rsp_region, rsp_blocked);
      end
      @(negedge clk) rst_n = 1'b1;

      // R1 overlay on lower half
      set_mode(1, 0, 0, 0, 1);
      issue("R1 ov1 p0", 0, 'h1234, 0, 0, 0);
      issue("R1 ov1 p5", 0, 'h4000, 5, 0, 0);
      set_mode(0, 0, 0, 0, 1);
      issue("R1 ov0 p0", 0, 'h1234, 0, 0, 0);
      issue("R1 ov0 p100", 0, 'h7FFF, 100, 0, 0);
      // R2 shared blocks and external pages
      issue("R2 p2", 0, 'h9000, 2, 0, 0);
      issue("R2 p0", 0, 'h8000, 0, 0, 0);
      issue("R2 p6", 0, 'h9000, 6, 0, 0);
      // R3 microprocessor mode
      set_mode(0, 1, 0, 1, 1);
      issue("R3 p1", 0, 'hA000, 1, 0, 0);
      issue("R3 p0 rom", 0, 'hE010, 0, 0, 0);
      // R4 aliasing
      set_mode(1, 0, 0, 0, 1);
      issue("R4 p66", 0, 'h9000, 'h42, 0, 0);
      issue("R4 p11", 0, 'hC000, 'h0B, 0, 0);
      issue("R4 p13", 0, 'h9000, 'h0D, 0, 0);
      issue("R4 p72 rsvd", 0, 'h0010, 72, 0, 0);
      // R5 data space
      set_mode(0, 0, 1, 0, 1);
      issue("R5 daram", 1, 'h2100, 9, 0, 0);
      issue("R5 saram", 1, 'hE100, 0, 0, 0);
      set_mode(0, 0, 0, 0, 1);
      issue("R5 ext", 1, 'h8100, 0, 0, 0);
      // R6 shared write protection
      issue("R6 cpu wr", 0, 'h8000, 1, 1, 0);
      issue("R6 dma wr", 0, 'h8000, 1, 1, 1);
      issue("R6 rd", 0, 'hF000, 3, 0, 0);
      // R7 interface gate
      set_mode(0, 0, 0, 0, 0);
      issue("R7 ext rd", 1, 'h8100, 0, 0, 0);
      issue("R7 ext wr", 1, 'h8100, 0, 1, 1);
      issue("R7 daram", 1, 'h0100, 0, 1, 0);
      // R8 boot ROM window
      set_mode(0, 0, 0, 1, 1);
      issue("R8 rom", 0, 'hE010, 0, 0, 0);
      issue("R8 rom wr", 0, 'hFFFF, 0, 1, 0);
      issue("R8 edge", 0, 'hDFFF, 0, 0, 0);
      issue("R8 p1", 0, 'hE010, 1, 0, 0);
      issue("R8 p8", 0, 'hE000, 8, 0, 0);
      set_mode(0, 0, 0, 0, 1);
      issue("R8 romen0", 0, 'hE010, 0, 0, 0);
      // R9 registers and reserved
      set_mode(1, 0, 0, 0, 1);
      issue("R9 mmr", 1, 'h005F, 0, 0, 0);
      issue("R9 data 60", 1, 'h0060, 0, 0, 0);
      issue("R9 rsvd p0", 0, 'h0010, 0, 0, 0);
      issue("R9 rsvd p3", 0, 'h0050, 3, 0, 0);
      issue("R9 p0 60", 0, 'h0060, 0, 0, 0);
      set_mode(0, 0, 0, 0, 1);
      issue("R9 p4 low", 0, 'h0010, 4, 0, 0);

      // R10 idle cycle
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      checks++;
      if (rsp_valid !== 1'b0) begin
         failures++;
         $display("FAIL R10 idle: got v=%0d exp 0", rsp_valid);
      end

      // R10 mixed sweep over all modes
      for (int i = 0; i < 400; i++) begin
         set_mode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 1));
         issue("R10 sweep", $urandom_range(0, 1), $urandom_range(0, 65535),
               $urandom_range(0, 127), $urandom_range(0, 1), $urandom_range(0, 1));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule